// File: doc/BRIEF.md
# BCD Time-of-Day Counter Chain

This block turns a 60 Hz line-derived tick into a 24-hour time of day. It keeps six BCD digits: seconds, minutes and hours. It runs on one system clock. The 60 Hz reference arrives as a one-cycle enable, `tick_60hz`. A prescaler made of a decade digit and a modulo-6 digit divides that reference down to one pulse per second. Two more stages of the same decade-then-modulo-6 form count seconds and minutes. A pair of decade hour digits follows, and it clears to 00 when the count would go past 23.

Each stage passes its carry to the next as a combinational clock enable, not as a derived clock. A whole cascade therefore settles in the same clock edge that takes the final 60 Hz tick. The once-per-second carry is also brought out as `sec_pulse`, so an indicator lamp can flash at 1 Hz.

Top module: `tod_bcd_chain`

## Requirements
- R1: While `rst` is high at a clock edge, every digit is cleared to 0 on that edge, and the clear has priority over `tick_60hz`.
- R2: On an edge where `tick_60hz` is low and `rst` is low, no digit output changes.
- R3: The prescaler divides by PRE_LO_MOD×PRE_HI_MOD (60 by default). `sec_pulse` is high exactly in the cycle of the tick that completes a group, and the seconds advance by one on that edge.
- R4: Seconds are two BCD digits. `sec_ones` counts 0–9 and `sec_tens` counts 0–5. Going from 59 to 00 advances the minutes on the same edge.
- R5: Minutes are two BCD digits with ranges 0–9 (`min_ones`) and 0–5 (`min_tens`). Going from 59 to 00 advances the hours on the same edge.
- R6: Hours are two BCD digits. They run from 00 to 23 and return to 00. The value 24, and any tens value above 2, never appears on the outputs.
- R7: The tick that arrives at 23:59:59 with a completed prescaler group produces 00:00:00 after a single clock edge.
- R8: The time value is a pure function of the number of ticks since reset: total seconds = ticks / 60, taken modulo 86400.
- R9: `sec_pulse` is low in every cycle where `tick_60hz` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_60hz | input | 1 | One-cycle enable per 60 Hz reference period |
| sec_ones | output | 4 | Seconds units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| min_ones | output | 4 | Minutes units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| hr_ones | output | 4 | Hours units digit, BCD |
| hr_tens | output | 4 | Hours tens digit, BCD |
| sec_pulse | output | 1 | One-cycle 1 Hz carry out of the prescaler |

## Verification
The bench builds two copies of the block. The first uses PRE_LO_MOD=1 and PRE_HI_MOD=1, which turns every tick into a whole second. That brings a full day, the 09→10 and 59→00 digit boundaries, the 23:59:59 midnight wrap, and the wrap after it within about 86 thousand cycles. The second copy keeps the default 10×6 prescaler on the same tick stream. It checks that `sec_pulse` lands on every sixtieth tick and that its seconds follow ticks divided by 60.

// File: rtl/tod_bcd_chain.sv
`timescale 1ns/1ps
module tod_bcd_chain #(
  parameter int PRE_LO_MOD = 10,
  parameter int PRE_HI_MOD = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_60hz,
  output logic [3:0] sec_ones,
  output logic [3:0] sec_tens,
  output logic [3:0] min_ones,
  output logic [3:0] min_tens,
  output logic [3:0] hr_ones,
  output logic [3:0] hr_tens,
  output logic       sec_pulse
);
  localparam int LW = (PRE_LO_MOD > 1) ? $clog2(PRE_LO_MOD) : 1;
  localparam int HW = (PRE_HI_MOD > 1) ? $clog2(PRE_HI_MOD) : 1;
  localparam logic [LW-1:0] LO_END = LW'(PRE_LO_MOD - 1);
  localparam logic [HW-1:0] HI_END = HW'(PRE_HI_MOD - 1);

  logic [LW-1:0] pre_lo;
  logic [HW-1:0] pre_hi;

  logic ce_pre_lo, ce_sec_lo, ce_sec, ce_min_lo, ce_min, ce_hr_lo, hr_wrap;

  assign ce_pre_lo = tick_60hz & (pre_lo == LO_END);
  assign sec_pulse = ce_pre_lo & (pre_hi == HI_END);
  assign ce_sec_lo = sec_pulse & (sec_ones == 4'd9);
  assign ce_sec    = ce_sec_lo & (sec_tens == 4'd5);
  assign ce_min_lo = ce_sec & (min_ones == 4'd9);
  assign ce_min    = ce_min_lo & (min_tens == 4'd5);
  assign ce_hr_lo  = ce_min & (hr_ones == 4'd9);
  assign hr_wrap   = ce_min & (hr_tens == 4'd2) & (hr_ones == 4'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_lo <= '0;
      pre_hi <= '0;
    end else begin
      if (tick_60hz) pre_lo <= (pre_lo == LO_END) ? '0 : pre_lo + LW'(1);
      if (ce_pre_lo) pre_hi <= (pre_hi == HI_END) ? '0 : pre_hi + HW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_ones <= '0;
      sec_tens <= '0;
      min_ones <= '0;
      min_tens <= '0;
    end else begin
      if (sec_pulse) sec_ones <= (sec_ones == 4'd9) ? 4'd0 : sec_ones + 4'd1;
      if (ce_sec_lo) sec_tens <= (sec_tens == 4'd5) ? 4'd0 : sec_tens + 4'd1;
      if (ce_sec)    min_ones <= (min_ones == 4'd9) ? 4'd0 : min_ones + 4'd1;
      if (ce_min_lo) min_tens <= (min_tens == 4'd5) ? 4'd0 : min_tens + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hr_wrap) begin
      hr_ones <= '0;
      hr_tens <= '0;
    end else begin
      if (ce_min)   hr_ones <= (hr_ones == 4'd9) ? 4'd0 : hr_ones + 4'd1;
      if (ce_hr_lo) hr_tens <= hr_tens + 4'd1;
    end
  end
endmodule

// File: rtl/tod_bcd_chain_chk.sv
`timescale 1ns/1ps
module tod_bcd_chain_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_60hz,
  input logic [3:0] sec_ones,
  input logic [3:0] sec_tens,
  input logic [3:0] min_ones,
  input logic [3:0] min_tens,
  input logic [3:0] hr_ones,
  input logic [3:0] hr_tens,
  input logic       sec_pulse
);
  logic [23:0] now;
  assign now = {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones};

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> now == 24'h0); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !tick_60hz |=> $stable(now)); // R2
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst) sec_pulse |=> !$stable({sec_tens, sec_ones})); // R3
  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst) sec_ones <= 4'd9 && sec_tens <= 4'd5); // R4
  AST_MIN_RANGE: assert property (@(posedge clk) disable iff (rst) min_ones <= 4'd9 && min_tens <= 4'd5); // R5
  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (rst) hr_ones <= 4'd9 && hr_tens <= 4'd2 && !(hr_tens == 4'd2 && hr_ones > 4'd3)); // R6
  AST_MIDNIGHT: assert property (@(posedge clk) disable iff (rst) (sec_pulse && now == 24'h235959) |=> now == 24'h0); // R7
  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst) sec_pulse |-> tick_60hz); // R9
endmodule

bind tod_bcd_chain tod_bcd_chain_chk u_chk (.*);

// File: tb/test_tod_bcd_chain.sv
`timescale 1ns/1ps
module test_tod_bcd_chain;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] f_so, f_st, f_mo, f_mt, f_ho, f_ht, p_so, p_st, p_mo, p_mt, p_ho, p_ht;
  logic f_pulse, p_pulse;
  logic [23:0] f_time, p_time;
  assign f_time = {f_ht, f_ho, f_mt, f_mo, f_st, f_so};
  assign p_time = {p_ht, p_ho, p_mt, p_mo, p_st, p_so};

  tod_bcd_chain #(.PRE_LO_MOD(1), .PRE_HI_MOD(1)) i_tod_bcd_chain (
    .clk(clk), .rst(rst), .tick_60hz(tick),
    .sec_ones(f_so), .sec_tens(f_st), .min_ones(f_mo), .min_tens(f_mt),
    .hr_ones(f_ho), .hr_tens(f_ht), .sec_pulse(f_pulse));

  tod_bcd_chain i_tod_bcd_chain_pre (
    .clk(clk), .rst(rst), .tick_60hz(tick),
    .sec_ones(p_so), .sec_tens(p_st), .min_ones(p_mo), .min_tens(p_mt),
    .hr_ones(p_ho), .hr_tens(p_ht), .sec_pulse(p_pulse));

  int checks = 0;
  int errors = 0;
  int fticks = 0;
  int pticks = 0;
  bit done = 1'b0;

  localparam int NV = 12;
  localparam int TGT [NV] = '{1, 9, 10, 59, 60, 3599, 3600, 35999, 36000, 86399, 86400, 86401};
  localparam logic [23:0] EXP [NV] = '{24'h000001, 24'h000009, 24'h000010, 24'h000059,
    24'h000100, 24'h005959, 24'h010000, 24'h095959, 24'h100000, 24'h235959,
    24'h000000, 24'h000001};

  function automatic logic [23:0] bcd_of(int secs);
    int s, h, m, x;
    s = secs % 86400;
    h = s / 3600;
    m = (s / 60) % 60;
    x = s % 60;
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(x / 10), 4'(x % 10)};
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic one_tick();
    tick = 1'b1;
    #1;
    check("R3 fast pulse", 24'(f_pulse), 24'h1);
    check("R3 prescaled pulse", 24'(p_pulse), 24'((pticks % 60) == 59));
    @(negedge clk);
    tick = 1'b0;
    fticks++;
    pticks++;
    check("R8 R4 R5 R6 time", f_time, bcd_of(fticks));
    check("R3 prescaled seconds", p_time, bcd_of(pticks / 60));
  endtask

  initial begin
    logic [23:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset fast", f_time, 24'h0);
    check("R1 reset prescaled", p_time, 24'h0);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      while (fticks < TGT[i]) one_tick();
      check("R7 boundary table", f_time, EXP[i]);
    end
    held = f_time;
    repeat (5) begin
      @(negedge clk);
      check("R2 idle hold", f_time, held);
      check("R9 pulse without tick", {22'h0, f_pulse, p_pulse}, 24'h0);
    end
    tick = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset over tick fast", f_time, 24'h0);
    check("R1 reset over tick prescaled", p_time, 24'h0);
    tick = 1'b0;
    rst = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule